// File: doc/BRIEF.md
# OTP fuse controller with write locking

This block sits between a simple register bus and a small one-time-programmable fuse array. The array is held inside the block as `WORDS` 32-bit words that come out of reset erased. A program access can only turn bits on: the new word is the old word ORed with the written data. Software selects a word with the address field of the control register. It arms a program access by writing the 16-bit unlock key into the top half of that register, and it fires the access by writing the data register. Each attempt uses up the key, so every program needs a fresh key write.

A program access can also lock its word for good. Any later program access aimed at a locked word, or at an address past the array, is refused. It raises the error flag and leaves the fuses as they were. Reads run as bursts of one to four consecutive words into four read data registers. When a burst ends, a done flag is set, and an error flag is also set if the burst ran past the last word. Each flag can drive the interrupt output through its own enable. A reload bit copies the whole array into a bank of shadow words that software can read. The bit clears itself when the copy is complete. The control register and the status register each have set, clear and toggle alias addresses.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control register (word 0), data register (4), read control register (5), status register (8), read data registers (12 to 15), lock status words (16 up) and shadow words (256 up) all read 0, and `irq` is 0.
- R2: A write to the data register starts a program access only when the unlock field (control bits 31:16) holds 0x3E77 at that moment. Any other key leaves the array unchanged. The unlock field always reads as 0 and is cleared by every write to the data register.
- R3: Control bit 10 (busy) reads 1 from the cycle after an accepted request until the access ends. A program access is busy for exactly `PROG_CYC` cycles (8 by default), a burst of N words for N cycles, and a reload for `WORDS` cycles. Otherwise busy reads 0.
- R4: A program access ORs the data register into the word selected by control bits 9:0. Bits already set can never be cleared.
- R5: A keyed program access to a word whose lock bit is set, or to an address of `WORDS` or more, sets control bit 11 (error), never reads busy, and does not change any fuse word.
- R6: When control bit 15 is 1, a successful program access sets the lock bit of its target word. When bit 15 is 0, the lock bits are unchanged. Lock bits never clear.
- R7: Writing 1 to control bit 12 while no reload is running starts a copy of every fuse word into its shadow word. Bit 12 reads 1 during the copy and 0 once the copy is done. Shadow words do not change on a program access.
- R8: Writing the read control register with bit 0 set starts a burst. Bits 2:1 give the length: 0, 1, 2 and 3 mean 1, 2, 3 and 4 words. Words are read from the control address upward into read data registers 0 onward. Registers beyond the burst length keep their previous values.
- R9: When a burst ends, status bit 22 (read done) is set. If any word of the burst lies at `WORDS` or above, that register is loaded with 0 and status bit 23 (read error) is set.
- R10: `irq` is 1 exactly when (status bit 22 and read control bit 3) or (status bit 23 and read control bit 4).
- R11: Control aliases at words 1, 2 and 3 and status aliases at words 9, 10 and 11 OR, clear or XOR the written ones into the register. Busy cannot be written.
- R12: Lock status word 16 holds the lock bits of fuse words 0 to 15 in bits 15:0. Each following lock word k (k = 1 up) holds the bits of words 16+32(k-1) to 47+32(k-1), with the lowest word number in bit 0.
- R13: A program, read or reload request that arrives while busy is ignored and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | ABW (9) | Register word address, used for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt from read done or read error |

## Verification
Register writes take effect at the clock edge that samples the strobe, and reads are combinational. Every check therefore samples one nanosecond after the falling edge that follows the last edge it depends on. Busy is checked twice for each access length: in the last cycle it must still be 1 (`PROG_CYC` or N edges after the request), and one edge later it must be 0. Read data, flags and the interrupt are only compared after the burst's final edge. The shadow bank is read only after more than `WORDS` cycles have passed since the reload request.

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
  parameter int WORDS    = 144,
  parameter int PROG_CYC = 8,
  parameter int ABW      = 9,
  parameter logic [15:0] KEY = 16'h3E77
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [ABW-1:0] addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic           irq
);
  localparam int IW   = $clog2(WORDS);
  localparam int LKW  = 1 + (WORDS - 16 + 31) / 32;
  localparam int LPAD = 16 + 32 * (LKW - 1);
  localparam int CMAX = (PROG_CYC > WORDS) ? PROG_CYC : WORDS;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [ABW-1:0] A_DATA = ABW'(4);
  localparam logic [ABW-1:0] A_RCTL = ABW'(5);
  localparam logic [ABW-1:0] A_LCK  = ABW'(16);

  typedef enum logic [1:0] {S_IDLE, S_PROG, S_READ, S_LOAD} st_t;

  st_t          st_q;
  logic [CW-1:0] cnt_q;
  logic [9:0]   adr_q, base_q;
  logic         err_q, wl_q, twl_q, ied_q, iee_q, dn_q, re_q;
  logic [15:0]  key_q;
  logic [1:0]   rlen_q;
  logic [31:0]  data_q;
  logic [31:0]  fuse [WORDS];
  logic [31:0]  shd  [WORDS];
  logic [31:0]  rd_q [4];
  logic [WORDS-1:0] lock_q;

  function automatic logic [31:0] alias_op(input logic [1:0] op, input logic [31:0] old, input logic [31:0] w);
    case (op)
      2'd0: alias_op = w;
      2'd1: alias_op = old | w;
      2'd2: alias_op = old & ~w;
      default: alias_op = old ^ w;
    endcase
  endfunction

  wire busy    = st_q != S_IDLE;
  wire loading = st_q == S_LOAD;
  wire [31:0] ctrl_int = {key_q, wl_q, 2'b00, loading, err_q, busy, adr_q};
  wire [31:0] stat_cur = {8'h00, re_q, dn_q, 22'h0};
  wire is_ctrl = wr_en && addr[ABW-1:2] == '0;
  wire is_stat = wr_en && addr[ABW-1:2] == (ABW-2)'(2);
  wire [31:0] ctrl_new = alias_op(addr[1:0], ctrl_int, wdata);
  wire [31:0] stat_new = alias_op(addr[1:0], stat_cur, wdata);
  wire wr_data = wr_en && addr == A_DATA;
  wire wr_rctl = wr_en && addr == A_RCTL;
  wire rd_req  = wr_rctl && wdata[0];
  wire ld_req  = is_ctrl && ctrl_new[12] && !loading;
  wire any_req = wr_data || rd_req || ld_req;
  wire tgt_ok  = adr_q < 10'(WORDS);
  wire tgt_lck = tgt_ok && lock_q[adr_q[IW-1:0]];
  wire [10:0] ra = {1'b0, base_q} + 11'(cnt_q);
  wire ra_ok   = ra < 11'(WORDS);
  wire [LPAD-1:0] lpad = LPAD'(lock_q);
  logic unused_bits;
  assign unused_bits = ^{ctrl_new[14:13], ctrl_new[10], stat_new[31:24], stat_new[21:0]};

  assign irq = (dn_q && ied_q) || (re_q && iee_q);

  always_comb begin
    rdata = '0;
    if (addr[ABW-1:2] == '0) rdata = {16'h0, ctrl_int[15:0]};
    else if (addr == A_DATA) rdata = data_q;
    else if (addr == A_RCTL) rdata = {27'h0, iee_q, ied_q, rlen_q, 1'b0};
    else if (addr == ABW'(8)) rdata = stat_cur;
    else if (addr[ABW-1:2] == (ABW-2)'(3)) rdata = rd_q[addr[1:0]];
    else if (addr == A_LCK) rdata = {16'h0, lpad[15:0]};
    else if (addr[ABW-1] && addr[ABW-2:0] < (ABW-1)'(WORDS)) rdata = shd[addr[IW-1:0]];
    for (int j = 1; j < LKW; j++)
      if (addr == A_LCK + ABW'(j)) rdata = lpad[16 + 32*(j-1) +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; adr_q <= '0; base_q <= '0;
      err_q <= 1'b0; wl_q <= 1'b0; twl_q <= 1'b0; ied_q <= 1'b0; iee_q <= 1'b0;
      dn_q <= 1'b0; re_q <= 1'b0; key_q <= '0; rlen_q <= '0; data_q <= '0; lock_q <= '0;
      for (int i = 0; i < 4; i++) rd_q[i] <= '0;
      for (int i = 0; i < WORDS; i++) begin fuse[i] <= '0; shd[i] <= '0; end
    end else begin
      if (is_ctrl) begin
        adr_q <= ctrl_new[9:0]; err_q <= ctrl_new[11];
        wl_q  <= ctrl_new[15];  key_q <= ctrl_new[31:16];
      end
      if (is_stat) begin dn_q <= stat_new[22]; re_q <= stat_new[23]; end
      if (wr_rctl && !(busy && wdata[0])) begin
        ied_q <= wdata[3]; iee_q <= wdata[4]; rlen_q <= wdata[2:1];
      end
      if (wr_data) key_q <= '0;
      if (wr_data && !busy) data_q <= wdata;
      if (busy && any_req) err_q <= 1'b1;
      case (st_q)
        S_IDLE: begin
          if (wr_data) begin
            if (key_q == KEY) begin
              if (tgt_lck || !tgt_ok) err_q <= 1'b1;
              else begin
                st_q <= S_PROG; cnt_q <= CW'(PROG_CYC - 1);
                base_q <= adr_q; twl_q <= wl_q;
              end
            end
          end else if (rd_req) begin
            st_q <= S_READ; cnt_q <= '0; base_q <= adr_q;
          end else if (ld_req) begin
            st_q <= S_LOAD; cnt_q <= '0;
          end
        end
        S_PROG: begin
          if (cnt_q == '0) begin
            fuse[base_q[IW-1:0]] <= fuse[base_q[IW-1:0]] | data_q;
            if (twl_q) lock_q[base_q[IW-1:0]] <= 1'b1;
            st_q <= S_IDLE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_READ: begin
          rd_q[cnt_q[1:0]] <= ra_ok ? fuse[ra[IW-1:0]] : 32'h0;
          if (!ra_ok) re_q <= 1'b1;
          if (cnt_q == CW'(rlen_q)) begin dn_q <= 1'b1; st_q <= S_IDLE; end
          else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          shd[cnt_q[IW-1:0]] <= fuse[cnt_q[IW-1:0]];
          if (cnt_q == CW'(WORDS - 1)) st_q <= S_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
  parameter int WORDS = 144,
  parameter int ABW   = 9,
  parameter logic [15:0] KEY = 16'h3E77
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [ABW-1:0]   addr,
  input logic             busy,
  input logic             err_q,
  input logic [15:0]      key_q,
  input logic [9:0]       adr_q,
  input logic [WORDS-1:0] lock_q,
  input logic             dn_q,
  input logic             ied_q,
  input logic             irq
);
  localparam int IW = $clog2(WORDS);
  wire data_wr = wr_en && addr == ABW'(4);
  wire hit_lock = (adr_q < 10'(WORDS)) && lock_q[adr_q[IW-1:0]];

  AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> key_q == 16'h0);  // R2

  AST_LOCKED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && data_wr && key_q == KEY && hit_lock) |=> (!busy && err_q));  // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((lock_q & $past(lock_q)) == $past(lock_q)));  // R6

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_wr) |=> err_q);  // R13

  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_q && ied_q) |-> irq);  // R10
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.WORDS(WORDS), .ABW(ABW), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .busy(busy), .err_q(err_q),
  .key_q(key_q), .adr_q(adr_q), .lock_q(lock_q), .dn_q(dn_q), .ied_q(ied_q), .irq(irq)
);

// File: tb/otp_fuse_ctrl_test.sv
module otp_fuse_ctrl_test;
  localparam logic [31:0] K = 32'h3E77_0000;
  typedef struct {bit is_irq; logic [8:0] a; logic [31:0] v; string tag;} item_t;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [8:0] d_addr = '0, m_addr = '0;
  logic mon_on = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  item_t q[$];
  int nvec = 0, nbad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  otp_fuse_ctrl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(mon_on ? m_addr : d_addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); d_addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic chk(input logic [8:0] a, input logic [31:0] v, input string tag);
    item_t it; it.is_irq = 0; it.a = a; it.v = v; it.tag = tag;
    q.push_back(it); wait (q.size() == 0);
  endtask
  task automatic chki(input logic v, input string tag);
    item_t it; it.is_irq = 1; it.a = '0; it.v = {31'h0, v}; it.tag = tag;
    q.push_back(it); wait (q.size() == 0);
  endtask
  task automatic prog(input logic [9:0] a, input logic [31:0] d, input logic wl);
    wr(0, K | (32'(wl) << 15) | 32'(a)); wr(4, d); idle(10);
  endtask
  task automatic rburst(input logic [9:0] a, input logic [1:0] len, input logic [1:0] ie);
    wr(0, 32'(a)); wr(5, (32'(ie) << 3) | (32'(len) << 1) | 32'h1); idle(6);
  endtask

  initial begin
    item_t it; logic [31:0] act;
    forever begin
      wait (q.size() > 0);
      it = q[0]; mon_on = 1'b1; m_addr = it.a; #1;
      act = it.is_irq ? {31'h0, irq} : rdata;
      nvec++;
      if (act !== it.v) begin
        nbad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, act, it.v);
      end
      mon_on = 1'b0; void'(q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nbad++; $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(1);
    chk(0, 0, "R1 ctrl"); chk(4, 0, "R1 data"); chk(5, 0, "R1 rctl"); chk(8, 0, "R1 stat");
    chk(12, 0, "R1 rd0"); chk(16, 0, "R1 lock0"); chk(20, 0, "R1 lock4");
    chk(256 + 5, 0, "R1 shadow"); chki(0, "R1 irq");
    // wrong key
    wr(0, 32'h1234_0000 | 32'd5); chk(0, 32'h5, "R2 key reads zero");
    wr(4, 32'hA5A5_0001); chk(0, 32'h5, "R2 no busy on bad key");
    rburst(5, 0, 0); chk(12, 0, "R2 fuse unchanged");
    // program with busy timing
    wr(0, K | 32'd5); wr(4, 32'h0000_00F0);
    chk(0, 32'h405, "R3 busy start");
    idle(7); chk(0, 32'h405, "R3 busy last cycle");
    idle(1); chk(0, 32'h005, "R3 busy drop");
    prog(5, 32'h0F00_0000, 0);
    rburst(5, 0, 1);
    chk(12, 32'h0F00_00F0, "R4 or");
    chk(8, 32'h0040_0000, "R9 done"); chki(1, "R10 done irq");
    prog(6, 32'h1111_2222, 0); prog(7, 32'hDEAD_BEEF, 0);
    wr(0, 32'd4); wr(5, 32'h7);
    chk(0, 32'h404, "R3 read busy");
    idle(3); chk(0, 32'h404, "R3 read busy last");
    idle(1); chk(0, 32'h004, "R3 read done");
    chk(12, 0, "R8 rd0"); chk(13, 32'h0F00_00F0, "R8 rd1");
    chk(14, 32'h1111_2222, "R8 rd2"); chk(15, 32'hDEAD_BEEF, "R8 rd3");
    chki(0, "R10 disabled");
    wr(10, 32'h0040_0000); chk(8, 0, "R11 status clear");
    prog(5, 32'h0, 0); rburst(5, 0, 0); chk(12, 32'h0F00_00F0, "R4 no clear");
    prog(6, 32'h1, 0); wr(4, 32'hFFFF_FFFF); idle(10);
    rburst(6, 0, 0); chk(12, 32'h1111_2223, "R2 key consumed");
    // locking
    prog(143, 32'h3, 1); prog(142, 32'h8000_0001, 0);
    chk(20, 32'h8000_0000, "R12 lock4"); chk(16, 0, "R6 no lock");
    prog(5, 32'h0, 1); chk(16, 32'h20, "R6 lock word5");
    prog(16, 32'h5, 1); chk(17, 32'h1, "R12 lock1 low");
    prog(47, 32'h1, 1); chk(17, 32'h8000_0001, "R12 lock1 high");
    wr(0, K | 32'd143); wr(4, 32'hFFFF_FFFF); chk(0, 32'h88F, "R5 locked err");
    idle(10); rburst(142, 1, 0);
    chk(12, 32'h8000_0001, "R8 rd0 w142"); chk(13, 32'h3, "R5 locked unchanged");
    wr(0, K | 32'd200); wr(4, 32'h1); chk(0, 32'h8C8, "R5 out of range");
    wr(10, 32'h00C0_0000);
    wr(0, 32'd142); wr(5, 32'h15); idle(6);
    chk(13, 32'h3, "R9 rd1"); chk(14, 0, "R9 beyond end");
    chk(15, 32'hDEAD_BEEF, "R8 rd3 kept");
    chk(8, 32'h00C0_0000, "R9 err flag"); chki(1, "R10 err irq"); chk(5, 32'h14, "R8 rctl");
    // aliases
    wr(10, 32'h0080_0000); chk(8, 32'h0040_0000, "R11 clr"); chki(0, "R10 done masked");
    wr(11, 32'h00C0_0000); chk(8, 32'h0080_0000, "R11 tog");
    wr(9, 32'h0040_0000); chk(8, 32'h00C0_0000, "R11 set");
    wr(8, 0); chk(8, 0, "R11 plain");
    wr(0, 32'h0AA); wr(1, 32'h8000); chk(0, 32'h80AA, "R11 ctrl set");
    wr(3, 32'h3FF | 32'h400); chk(0, 32'h8355, "R11 ctrl tog");
    wr(2, 32'h8000); chk(0, 32'h0355, "R11 ctrl clr");
    wr(1, 32'h800); chk(0, 32'h0B55, "R11 err set");
    wr(2, 32'h800); chk(0, 32'h0355, "R11 err clr");
    // request while busy
    wr(0, K | 32'd10); wr(4, 32'h77); wr(5, 32'h1);
    chk(0, 32'hC0A, "R13 err while busy");
    idle(10); chk(0, 32'h80A, "R13 after");
    chk(12, 32'h8000_0001, "R13 read ignored"); chk(8, 0, "R13 no done");
    rburst(10, 0, 0); chk(12, 32'h77, "R4 program under reject");
    // reload
    chk(256 + 5, 0, "R7 shadow before");
    wr(1, 32'h1000); chk(0, 32'h140A, "R7 reloading");
    idle(150); chk(0, 32'h00A, "R7 self clear");
    chk(256 + 5, 32'h0F00_00F0, "R7 shadow5"); chk(256 + 143, 32'h3, "R7 shadow143");
    chk(256 + 6, 32'h1111_2223, "R7 shadow6");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule